// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged Receive Queue

This block turns a start/stop framed serial line into characters and puts them in a 16-deep receive queue. The line is sampled on an oversampling enable (16 enables per bit). Software picks 7 or 8 data bits, parity on or off, odd or even parity, and one or two stop bits.

Every character that passes start-bit validation goes into the queue with two tags: framing error and parity error. A bad character never stops reception. The character is stored like any other and the next one is received normally. A sticky summary flag records that some character was bad. A second sticky flag records that a character was lost because the queue was full. Software clears either flag with a handshake: it reads the flag as 1, then writes 0 to it. The queue head is always visible on the read port, and a pop strobe removes it.

Top module: `uart_rx_errfifo`

## Requirements
- R1: Data bits arrive LSB first. When `len8_i`=1 there are 8 data bits. When `len8_i`=0 there are 7, and bit 7 of `fifo_data_o` reads 0. The head of the queue is shown on `fifo_data_o`, `fifo_fer_o` and `fifo_per_o`.
- R2: A start bit is taken only after a high-to-low edge on the line where the line is still low 8 enables later. A shorter low pulse stores nothing.
- R3: The first stop bit is sampled at its centre. If it is 0, the stored character has `fifo_fer_o`=1. With `stop2_i`=1, the second stop bit is waited out but never checked.
- R4: With `par_en_i`=1, a parity bit follows the data. `fifo_per_o`=1 when the number of 1s in data plus parity bit is odd with `par_odd_i`=0, or even with `par_odd_i`=1. With `par_en_i`=0, no parity bit is expected and the tag is 0.
- R5: A character with an error is still stored, and the next character is received and stored correctly.
- R6: `err_o` is 0 after reset. It becomes 1 for any character with a framing or parity error, including a character dropped because the queue is full.
- R7: A status write with bit 0 = 0 clears `err_o` only if the last status access before it was a read that returned `err_o`=1. Any other write leaves the flag as it is and cancels an earlier read. Bit 1 controls `ovr_o` in the same way.
- R8: While `rx_en_i`=0 the receiver stays idle and stores nothing. `err_o` and `ovr_o` keep their values.
- R9: The queue holds 16 entries and returns them in arrival order. `fifo_empty_o` and `fifo_full_o` report its state. A pop while the queue is empty has no effect.
- R10: A character that completes while the queue is full is dropped, and `ovr_o` becomes 1 and stays 1.
- R11: A character is stored on the clock edge where the first stop bit is sampled. With one enable per clock, this is the 155th rising edge after the start edge for 8 data bits without parity. Each extra data or parity bit adds 16 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| stop2_i | input | 1 | Two stop bits |
| len8_i | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| st_rd_i | input | 1 | Status read strobe |
| st_wr_i | input | 1 | Status write strobe |
| st_wdata_i | input | 2 | Write data: bit 0 for the error flag, bit 1 for the overrun flag |
| err_o | output | 1 | Sticky receive-error flag |
| ovr_o | output | 1 | Sticky overrun flag |
| fifo_pop_i | input | 1 | Remove the head entry |
| fifo_data_o | output | 8 | Head character |
| fifo_fer_o | output | 1 | Head framing-error tag |
| fifo_per_o | output | 1 | Head parity-error tag |
| fifo_empty_o | output | 1 | Queue empty |
| fifo_full_o | output | 1 | Queue full |

## Verification
The line passes through a two-stage synchronizer. The start check then adds 8 enables and each bit adds 16, so a character appears in the queue at the edge given by R11. The directed timing test samples `fifo_empty_o` on the falling edges just before and just after that rising edge. Status reads, writes and pops act on the first rising edge after their strobe. The bench checks their effect on the next falling edge, and it pops only after a whole frame and a guard bit have gone by. The random frames are checked against a queue of expected entries that the bench works out from the data, the configuration and the errors it injected.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OSR    = 16;

  typedef struct packed {
    logic              fer;
    logic              per;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = OSR
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      en_i,
  input  logic      rxd_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  input  logic      stop2_i,
  input  logic      len8_i,
  output logic      push_o,
  output rx_entry_t entry_o
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned BW   = $clog2(DATA_W);
  localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              prev_q;
  logic [BW-1:0]     last_bit;
  logic              bit_end;
  logic [DATA_W-1:0] data_w;

  assign last_bit = len8_i ? BW'(DATA_W-1) : BW'(DATA_W-2);
  assign bit_end  = (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else if (tick_i) prev_q <= rxd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (prev_q && !rxd_i) state_q <= ST_START;
        end
        ST_START: begin
          if (cnt_q == HALF) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= rxd_i ? ST_IDLE : ST_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (bit_end) begin
            sh_q <= {rxd_i, sh_q[DATA_W-1:1]};
            if (bit_q == last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
            else bit_q <= bit_q + 1'b1;
          end
        end
        ST_PAR: begin
          cnt_q <= cnt_q + 1'b1;
          if (bit_end) begin
            par_q   <= rxd_i;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          cnt_q <= cnt_q + 1'b1;
          if (bit_end) state_q <= stop2_i ? ST_SKIP : ST_IDLE;
        end
        ST_SKIP: begin
          cnt_q <= cnt_q + 1'b1;
          if (bit_end) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // 7-bit frames end one position high in the shifter
  assign data_w = len8_i ? sh_q : {1'b0, sh_q[DATA_W-1:1]};

  assign push_o       = en_i && tick_i && (state_q == ST_STOP) && bit_end;
  assign entry_o.data = data_w;
  assign entry_o.fer  = !rxd_i;
  assign entry_o.per  = par_en_i && ((^data_w) ^ par_q ^ par_odd_i);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned WIDTH = 10,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             drop_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [AW:0]      cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
  parameter int unsigned NFLAG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [NFLAG-1:0] wdata_i,
  output logic [NFLAG-1:0] flag_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic flag_q, arm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else begin
        if (wr_i)      arm_q <= 1'b0;
        else if (rd_i) arm_q <= flag_q;
        // a new event outranks a clear in the same cycle
        if (set_i[g])                           flag_q <= 1'b1;
        else if (wr_i && arm_q && !wdata_i[g])  flag_q <= 1'b0;
      end
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned OVS        = OSR,
  parameter int unsigned SYNC_N     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              len8_i,
  input  logic              st_rd_i,
  input  logic              st_wr_i,
  input  logic [1:0]        st_wdata_i,
  output logic              err_o,
  output logic              ovr_o,
  input  logic              fifo_pop_i,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              fifo_fer_o,
  output logic              fifo_per_o,
  output logic              fifo_empty_o,
  output logic              fifo_full_o
);
  localparam int unsigned EW = $bits(rx_entry_t);

  logic [SYNC_N-1:0] sync_q;
  logic              push;
  rx_entry_t         entry, head;
  logic              drop;
  logic [1:0]        flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], rxd_i};
  end

  uart_rx_frame #(.OVS(OVS)) frame_i (
    .clk_i, .rst_ni, .tick_i,
    .en_i      (rx_en_i),
    .rxd_i     (sync_q[SYNC_N-1]),
    .par_en_i, .par_odd_i, .stop2_i, .len8_i,
    .push_o    (push),
    .entry_o   (entry)
  );

  uart_rx_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .push_i  (push),
    .wdata_i (entry),
    .pop_i   (fifo_pop_i),
    .rdata_o (head),
    .empty_o (fifo_empty_o),
    .full_o  (fifo_full_o),
    .drop_o  (drop)
  );

  uart_rx_sticky #(.NFLAG(2)) sticky_i (
    .clk_i, .rst_ni,
    .set_i   ({drop, push && (entry.fer || entry.per)}),
    .rd_i    (st_rd_i),
    .wr_i    (st_wr_i),
    .wdata_i (st_wdata_i),
    .flag_o  (flags)
  );

  assign err_o       = flags[0];
  assign ovr_o       = flags[1];
  assign fifo_data_o = head.data;
  assign fifo_fer_o  = head.fer;
  assign fifo_per_o  = head.per;
endmodule

// File: rtl/uart_rx_errfifo_chk.sv
module uart_rx_errfifo_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       st_rd_i,
  input logic       st_wr_i,
  input logic [1:0] st_wdata_i,
  input logic       err_o,
  input logic       ovr_o,
  input logic       fifo_empty_o,
  input logic       fifo_full_o
);
  logic arm_err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      arm_err_q <= 1'b0;
    else if (st_wr_i) arm_err_q <= 1'b0;
    else if (st_rd_i) arm_err_q <= err_o;
  end

  // R9
  empty_full_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_empty_o && fifo_full_o));

  // R7
  err_clear_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(arm_err_q && st_wr_i && !st_wdata_i[0]));

  // R10
  ovr_rise_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(fifo_full_o));

  // R10
  ovr_fall_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_o) |-> $past(st_wr_i && !st_wdata_i[1]));

  // R8
  idle_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && fifo_empty_o) |=> fifo_empty_o);

  // R8
  idle_err_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !st_wr_i) |=> $stable(err_o));
endmodule

bind uart_rx_errfifo uart_rx_errfifo_chk chk_i (
  .clk_i, .rst_ni, .rx_en_i, .st_rd_i, .st_wr_i, .st_wdata_i,
  .err_o, .ovr_o, .fifo_empty_o, .fifo_full_o
);

// File: tb/uart_rx_errfifo_tb_top.sv
module uart_rx_errfifo_tb_top;
  localparam int BIT_T = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, rxd = 1'b1, rx_en = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, len8 = 1'b1;
  logic st_rd = 1'b0, st_wr = 1'b0, pop = 1'b0;
  logic [1:0] st_wd = 2'b11;
  logic err, ovr, fer, per, empty, full;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  logic [9:0] exp_q[$];
  logic exp_err = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_errfifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .rx_en_i(rx_en),
    .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2), .len8_i(len8),
    .st_rd_i(st_rd), .st_wr_i(st_wr), .st_wdata_i(st_wd),
    .err_o(err), .ovr_o(ovr), .fifo_pop_i(pop), .fifo_data_o(rdata),
    .fifo_fer_o(fer), .fifo_per_o(per), .fifo_empty_o(empty), .fifo_full_o(full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] model(input logic [7:0] d, input bit l8, input bit pe,
                                       input bit bstop, input bit bpar);
    logic [7:0] dm = l8 ? d : {1'b0, d[6:0]};
    return {bstop, pe & bpar, dm};
  endfunction

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT_T) @(negedge clk);
  endtask

  // called at a negedge with the receiver idle
  task automatic send(input logic [7:0] d, input bit l8, input bit pe, input bit po,
                      input bit s2, input bit bstop, input bit bpar, input bit s2low);
    logic [7:0] dm = l8 ? d : {1'b0, d[6:0]};
    len8 = l8; par_en = pe; par_odd = po; stop2 = s2;
    drive_bit(1'b0);
    for (int i = 0; i < (l8 ? 8 : 7); i++) drive_bit(dm[i]);
    if (pe) drive_bit((^dm) ^ po ^ bpar);
    drive_bit(!bstop);
    if (s2) drive_bit(!s2low);
    drive_bit(1'b1);
  endtask

  task automatic send_exp(input logic [7:0] d, input bit l8, input bit pe, input bit po,
                          input bit s2, input bit bstop, input bit bpar, input bit s2low);
    send(d, l8, pe, po, s2, bstop, bpar, s2low);
    exp_q.push_back(model(d, l8, pe, bstop, bpar));
    if (bstop || (pe && bpar)) exp_err = 1'b1;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      logic [9:0] e = exp_q.pop_front();
      chk({req, " not empty"}, empty, 1'b0);
      chk({req, " entry"}, {fer, per, rdata}, e);
      pop = 1'b1; @(negedge clk); pop = 1'b0;
    end
    chk({req, " empty after drain"}, empty, 1'b1);
  endtask

  task automatic st_read();
    st_rd = 1'b1; @(negedge clk); st_rd = 1'b0;
  endtask

  task automatic st_write(input logic [1:0] wd);
    st_wd = wd; st_wr = 1'b1; @(negedge clk); st_wr = 1'b0; st_wd = 2'b11;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 R9 reset state
    chk("R9 reset empty", empty, 1'b1);
    chk("R9 reset full", full, 1'b0);
    chk("R6 reset err", err, 1'b0);
    chk("R10 reset ovr", ovr, 1'b0);
    repeat (20) @(negedge clk);

    // R11 due edge, R1 8-bit data
    fork
      send_exp(8'hA5, 1, 0, 0, 0, 0, 0, 0);
      begin
        repeat (154) @(negedge clk);
        chk("R11 empty before due edge", empty, 1'b1);
        @(negedge clk);
        chk("R11 stored on due edge", empty, 1'b0);
      end
    join
    drain("R1 8-bit");

    // R1 7-bit
    send_exp(8'hFF, 0, 0, 0, 0, 0, 0, 0);
    drain("R1 7-bit");

    // R2 short glitch
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 glitch stores nothing", empty, 1'b1);

    // R4 parity, R6 flag
    send_exp(8'h3C, 1, 1, 1, 0, 0, 0, 0);
    chk("R6 good odd parity keeps err", err, 1'b0);
    send_exp(8'h81, 1, 1, 0, 0, 0, 1, 0);
    chk("R6 parity error sets err", err, 1'b1);
    send_exp(8'h13, 0, 1, 0, 0, 0, 0, 0);
    drain("R4 parity");

    // R3 framing then R5 continued reception, 2nd stop ignored
    send_exp(8'h5A, 1, 0, 0, 0, 1, 0, 0);
    send_exp(8'hC3, 1, 0, 0, 1, 0, 0, 1);
    send_exp(8'h77, 1, 1, 0, 1, 1, 0, 0);
    drain("R3 R5 framing");

    // R7 handshake
    chk("R7 err set", err, 1'b1);
    st_write(2'b10);
    chk("R7 write without read keeps", err, 1'b1);
    st_read();
    st_write(2'b11);
    chk("R7 write 1 keeps", err, 1'b1);
    st_write(2'b10);
    chk("R7 write after cancelled read keeps", err, 1'b1);
    st_read();
    st_write(2'b10);
    chk("R7 read 1 then write 0 clears", err, 1'b0);

    // R8 disabled receiver keeps flag, stores nothing
    send_exp(8'h00, 1, 1, 0, 0, 0, 1, 0);
    drain("R8 setup");
    rx_en = 1'b0;
    send(8'h55, 1, 0, 0, 0, 1, 0, 0);
    chk("R8 disabled stores nothing", empty, 1'b1);
    chk("R8 disabled keeps err", err, 1'b1);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    st_read(); st_write(2'b10);
    exp_err = 1'b0;
    chk("R7 cleared", err, 1'b0);

    // R9 pop on empty ignored
    pop = 1'b1; @(negedge clk); pop = 1'b0;
    chk("R9 pop on empty", empty, 1'b1);
    send_exp(8'h9E, 1, 0, 0, 0, 0, 0, 0);
    drain("R9 after empty pop");

    // R9 R10 fill and overflow
    for (int i = 0; i < 16; i++) send_exp(8'(i * 13 + 1), 1, 0, 0, 0, 0, 0, 0);
    chk("R9 full at 16", full, 1'b1);
    chk("R10 no ovr yet", ovr, 1'b0);
    send(8'hEE, 1, 0, 0, 0, 1, 0, 0);
    chk("R10 ovr set", ovr, 1'b1);
    chk("R6 dropped bad char sets err", err, 1'b1);
    drain("R9 order");
    chk("R10 ovr sticky", ovr, 1'b1);
    st_read(); st_write(2'b01);
    chk("R10 ovr cleared", ovr, 1'b0);
    chk("R10 err untouched", err, 1'b1);
    st_read(); st_write(2'b10);
    exp_err = 1'b0;

    // random frames
    void'($urandom(32'h1d2c));
    for (int n = 0; n < 30; n++) begin
      logic [7:0] d = 8'($urandom);
      bit l8 = 1'($urandom), pe = 1'($urandom), po = 1'($urandom), s2 = 1'($urandom);
      bit bs = ($urandom % 5) == 0, bp = ($urandom % 4) == 0, sl = 1'($urandom);
      send_exp(d, l8, pe, po, s2, bs, bp, sl);
      chk("R6 random err", err, exp_err);
      drain("R1 R3 R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule